// File: doc/BRIEF.md
# Half-Duplex Command/Reply Serial Master

This block is the master end of a half-duplex serial link. It accepts an 8-bit command word from the system side through a valid/ready handshake. It pulls its active-low select line low and shifts the command out most-significant bit first. It then lets one idle serial clock pass as a turnaround. After that it shifts in a reply of 4 to 16 bits from the slave, also most-significant bit first. The data-in line is ignored for the whole command phase and for the turnaround clock.

The serial clock comes from a divider on the system clock, and its period is 2*(DIV+1) system clocks. The serial clock rests low outside a frame and toggles only while select is low. The master changes its data output just after each falling serial edge and samples the slave on each rising edge. When the last reply bit is in, select goes high and the reply appears right-aligned on a 16-bit output. A one-cycle valid pulse marks it.

The control is a three-state machine. `ST_IDLE` holds select high and the clock low, and it moves to `ST_LOW` when a command is accepted (transition *start*). `ST_LOW` is the low half of a serial clock, and it moves to `ST_HIGH` on a divider tick (transition *rise*, where the reply may be sampled). `ST_HIGH` is the high half. On a tick it returns to `ST_LOW` if more clocks remain (transition *fall*, where the command is shifted). On the tick of the last clock it returns to `ST_IDLE` (transition *finish*).

Top module: `hdx_cmd_master`

## Requirements
- R1: `cmd_ready` is high only while no frame is in progress. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. In the next cycle `sel_n` is low and `cmd_ready` is low.
- R2: The 8 command bits appear on `mosi` MSB first. The first bit is present from the cycle after acceptance, and each later bit replaces the previous one only at a falling `sclk` edge. `mosi` never changes while `sclk` is high.
- R3: `miso` has no effect on the reply during the 8 command clocks or the ninth (turnaround) clock.
- R4: The reply length N is `reply_len`+1 for settings 3 to 15, and 4 for settings 0, 1 and 2. Reply bits are sampled MSB first at the rising `sclk` edges of clocks 10 to 9+N. The setting is captured when the command is accepted, so later changes do not alter that frame.
- R5: `sclk` is low whenever `sel_n` is high. A frame has exactly 9+N rising `sclk` edges while `sel_n` is low.
- R6: Each half of a serial clock lasts `div`+1 system clocks, so `sel_n` stays low for exactly (9+N)*2*(`div`+1) system clocks.
- R7: `rsp_valid` is high for exactly one cycle: the first cycle in which `sel_n` is high again after a frame. `rsp_data` then holds the N reply bits in its low bits, with zeros above them.
- R8: `mosi` is low during the turnaround clock, the reply clocks and idle.
- R9: While reset is held and right after it, `sel_n`=1, `sclk`=0, `mosi`=0, `rsp_valid`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| cmd_data | input | 8 | Command word, sent MSB first |
| reply_len | input | 4 | Reply length setting (N = value+1, minimum 4) |
| div | input | 8 | Half-period of the serial clock minus one, in system clocks |
| sclk | output | 1 | Serial clock, idle low |
| sel_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| rsp_valid | output | 1 | One-cycle pulse: reply word ready |
| rsp_data | output | 16 | Reply word, right-aligned and zero-filled |

## Verification
The properties assume that `div` stays constant during a frame and that the inputs are synchronous to `clk`. The stimulus changes `div` only between frames and drives every input at the falling system edge. It lets `reply_len` and `cmd_valid` change mid-frame, because the design must tolerate both. The slave model drives `miso` high during the command and turnaround clocks, so that any sample taken too early would show up as ones above the reply. It changes `miso` only after a falling serial edge, which keeps the master's sampling point clear of a changing input.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } hdx_state_t;
endpackage

// File: rtl/hdx_clkdiv.sv
module hdx_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hdx_frame_ctrl.sv
module hdx_frame_ctrl
    import hdx_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int LEN_W   = 4,
    parameter int MIN_RSP = 4,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [LEN_W-1:0] reply_len,
    input  logic             tick,
    output logic             idle,
    output logic             sclk_hi,
    output logic             start,
    output logic             sample,
    output logic             shift,
    output logic             finish
);
    hdx_state_t       state, state_nx;
    logic [IDX_W-1:0] clk_idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] len_p1;
    logic [IDX_W-1:0] eff_len;
    logic             is_last;

    assign len_p1  = IDX_W'(reply_len) + 1'b1;
    assign eff_len = (len_p1 < IDX_W'(MIN_RSP)) ? IDX_W'(MIN_RSP) : len_p1;
    assign is_last = (clk_idx == last_idx);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) state_nx = ST_LOW;
            ST_LOW:  if (tick)      state_nx = ST_HIGH;
            ST_HIGH: if (tick)      state_nx = is_last ? ST_IDLE : ST_LOW;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // state register with clock index and latched frame length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            clk_idx  <= '0;
            last_idx <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                clk_idx  <= '0;
                last_idx <= IDX_W'(CMD_W) + eff_len;
            end else if (shift) begin
                clk_idx <= clk_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        idle    = 1'b0;
        sclk_hi = 1'b0;
        start   = 1'b0;
        sample  = 1'b0;
        shift   = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle  = 1'b1;
                start = cmd_valid;
            end
            ST_LOW:  sample = tick && (clk_idx > IDX_W'(CMD_W));
            ST_HIGH: begin
                sclk_hi = 1'b1;
                shift   = tick && !is_last;
                finish  = tick && is_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hdx_shifter.sv
module hdx_shifter #(
    parameter int CMD_W = 8,
    parameter int RSP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] cmd,
    input  logic             shift,
    input  logic             sample,
    input  logic             miso,
    output logic             mosi,
    output logic [RSP_W-1:0] rsp
);
    logic [CMD_W-1:0] tx_sr;
    logic [RSP_W-1:0] rx_sr;

    assign mosi = tx_sr[CMD_W-1];
    assign rsp  = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= cmd;
            rx_sr <= '0;
        end else begin
            if (shift)
                tx_sr <= {tx_sr[CMD_W-2:0], 1'b0};
            if (sample)
                rx_sr <= {rx_sr[RSP_W-2:0], miso};
        end
    end
endmodule

// File: rtl/hdx_cmd_master.sv
module hdx_cmd_master #(
    parameter int CMD_W   = 8,
    parameter int RSP_W   = 16,
    parameter int MIN_RSP = 4,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic [$clog2(RSP_W)-1:0] reply_len,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             sel_n,
    output logic             mosi,
    input  logic             miso,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_data
);
    localparam int LEN_W = $clog2(RSP_W);
    localparam int IDX_W = $clog2(CMD_W + 1 + RSP_W + 1);

    logic idle, sclk_hi, start, sample, shift, finish, tick;

    hdx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!idle), .div(div), .tick(tick)
    );

    hdx_frame_ctrl #(
        .CMD_W(CMD_W), .LEN_W(LEN_W), .MIN_RSP(MIN_RSP), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .reply_len(reply_len),
        .tick(tick), .idle(idle), .sclk_hi(sclk_hi), .start(start),
        .sample(sample), .shift(shift), .finish(finish)
    );

    hdx_shifter #(.CMD_W(CMD_W), .RSP_W(RSP_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(start), .cmd(cmd_data), .shift(shift),
        .sample(sample), .miso(miso), .mosi(mosi), .rsp(rsp_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= finish;
    end

    assign cmd_ready = idle;
    assign sel_n     = idle;
    assign sclk      = sclk_hi;
endmodule

// File: rtl/hdx_cmd_master_chk.sv
module hdx_cmd_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic sclk,
    input logic sel_n,
    input logic mosi,
    input logic rsp_valid
);
    a_r5_clk_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sclk);

    a_r1_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!sel_n && !cmd_ready));

    a_r2_mosi_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    a_r7_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_valid_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> rsp_valid);

    a_r8_mosi_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !rsp_valid && $past(sel_n)) |-> !mosi);
endmodule

bind hdx_cmd_master hdx_cmd_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .sclk(sclk), .sel_n(sel_n), .mosi(mosi), .rsp_valid(rsp_valid)
);

// File: tb/hdx_cmd_master_test.sv
module hdx_cmd_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_data = '0;
    logic [3:0]  reply_len = '0;
    logic [7:0]  div = '0;
    logic        sclk, sel_n, mosi;
    logic        miso = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    hdx_cmd_master uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .reply_len(reply_len), .div(div), .sclk(sclk),
        .sel_n(sel_n), .mosi(mosi), .miso(miso), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    // slave model, sampled at the falling system edge
    logic [15:0] sl_reply = '0;
    int          sl_n = 4;
    int          sl_rise = 0;
    int          sl_fall = 0;
    int          sl_mosi_bad = 0;
    logic [7:0]  sl_cmd = '0;
    logic        p_sclk = 1'b0;
    logic        p_sel = 1'b1;

    always @(negedge clk) begin
        if (p_sel && !sel_n) begin
            sl_rise = 0; sl_fall = 0; sl_mosi_bad = 0; sl_cmd = '0;
            miso = 1'b1;
        end
        if (!p_sclk && sclk) begin
            if (sl_rise < 8) sl_cmd = {sl_cmd[6:0], mosi};
            else if (mosi !== 1'b0) sl_mosi_bad++;
            sl_rise++;
        end
        if (p_sclk && !sclk) begin
            if (sl_fall >= 8 && sl_fall - 8 < sl_n)
                miso = sl_reply[sl_n - 1 - (sl_fall - 8)];
            else
                miso = 1'b1;
            sl_fall++;
        end
        p_sclk = sclk;
        p_sel  = sel_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  cmd;
        logic [3:0]  len;
        logic [7:0]  dv;
        logic [15:0] reply;
        logic [4:0]  nbits;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 4'd15, 8'd0, 16'hBEEF, 5'd16, 16'hBEEF},
        '{8'h3C, 4'd7,  8'd1, 16'hFF5A, 5'd8,  16'h005A},
        '{8'h81, 4'd3,  8'd2, 16'h000B, 5'd4,  16'h000B},
        '{8'h00, 4'd0,  8'd0, 16'h0007, 5'd4,  16'h0007},
        '{8'hFF, 4'd11, 8'd3, 16'h0ABC, 5'd12, 16'h0ABC},
        '{8'h6E, 4'd2,  8'd1, 16'hFFFF, 5'd4,  16'h000F}
    };

    task automatic run_frame(input vec_t v, input bit poke);
        int cyc;
        sl_reply = v.reply;
        sl_n     = int'(v.nbits);
        @(negedge clk);
        cmd_data = v.cmd; reply_len = v.len; div = v.dv; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 select low after accept", {31'd0, sel_n}, 32'd0);
        cyc = 0;
        while (sel_n == 1'b0) begin
            cyc++;
            if (poke && cyc == 10) reply_len = 4'd3;
            if (poke && cyc == 12) begin cmd_valid = 1'b1; cmd_data = 8'h11; end
            if (poke && cyc == 13) begin
                chk("R1 ready low during frame", {31'd0, cmd_ready}, 32'd0);
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R6 select low duration", cyc, (9 + int'(v.nbits)) * 2 * (int'(v.dv) + 1));
        chk("R7 valid at frame end", {31'd0, rsp_valid}, 32'd1);
        chk("R4 R3 R7 reply word", {16'd0, rsp_data}, {16'd0, v.exp});
        @(negedge clk);
        chk("R7 valid single cycle", {31'd0, rsp_valid}, 32'd0);
        chk("R7 data held", {16'd0, rsp_data}, {16'd0, v.exp});
        chk("R2 command seen by slave", {24'd0, sl_cmd}, {24'd0, v.cmd});
        chk("R5 rising edges per frame", sl_rise, 9 + int'(v.nbits));
        chk("R8 mosi low after command", sl_mosi_bad, 0);
        chk("R5 clock low when idle", {31'd0, sclk}, 32'd0);
        chk("R8 mosi low when idle", {31'd0, mosi}, 32'd0);
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 sel_n in reset", {31'd0, sel_n}, 32'd1);
        chk("R9 sclk in reset", {31'd0, sclk}, 32'd0);
        chk("R9 mosi in reset", {31'd0, mosi}, 32'd0);
        chk("R9 valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 ready after reset", {31'd0, cmd_ready}, 32'd1);
        chk("R9 sel_n after reset", {31'd0, sel_n}, 32'd1);

        for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);

        // R4 length latched at acceptance; R1 busy command ignored
        run_frame('{8'h5A, 4'd15, 8'd0, 16'h1234, 5'd16, 16'h1234}, 1'b1);
        // back-to-back after the ignored offer: next frame is unaffected
        run_frame('{8'hC3, 4'd1, 8'd0, 16'hFFF9, 5'd4, 16'h0009}, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule